// File: doc/BRIEF.md
# Boot Load Sequencer with Ready Signal

This block runs the start-up of a device after its reset is released. It first waits a fixed interval of 22 ms. It then pulls a set of configuration words from non-volatile storage. Each read is a request/acknowledge handshake with an abstract storage port, and each read has its own timeout. The flow-control line toward the host (`rts`, active low) stays high from reset until the load is over. Once the last word arrives, `rts` goes low and the three-character ready message "ROK" is handed byte by byte to a serial transmitter.

During the first 27 ms of a start-up, a low level on the supply-good input means the supply has dipped. A dip inside that window could corrupt the stored data, so the block pulses a brownout reset and restarts the whole sequence from the 22 ms wait. A dip after the window has no effect. If a read is not acknowledged in time, the block parks in an error state with `rts` still high.

All intervals come from a clock-rate parameter in kHz. The reset input is synchronised with two flops, so the sequence clock starts two cycles after `rst_n` rises.

Top module: `boot_seq_top`

## Requirements
- R1: The first read request (`rd_req` high) appears exactly 22*CLK_KHZ cycles after the sequence start, where the sequence start is the second clock edge after `rst_n` rises.
- R2: `rts` is high whenever `rd_req` is high, and `rts` stays high from reset until the load finishes.
- R3: Reads use addresses 0 to NUM_WORDS-1 in ascending order. Each address is held with `rd_req` high until `rd_ack` is sampled high at a clock edge.
- R4: One cycle after the edge that accepts the last acknowledge, `rts` is low, `rd_req` is low and `tx_valid` is high. `tx_valid` is never high while `rts` is high.
- R5: The ready message is the bytes 0x52 ('R'), 0x4F ('O') and 0x4B ('K'), in that order. Each byte is held stable with `tx_valid` high until it is accepted by `tx_ready` at an edge.
- R6: One cycle after the last byte is accepted, `tx_valid` is low. On the cycle after that, `boot_done` is high, and it stays high with `rts` low.
- R7: If a read has waited ACK_TIMEOUT edges without an acknowledge, `boot_err` rises one cycle later. While `boot_err` is high, `rts` is high and no request is made. An acknowledge sampled at the ACK_TIMEOUT-th edge of a read is still accepted.
- R8: `supply_ok` low at an edge where fewer than 27*CLK_KHZ cycles have passed since the sequence start gives a one-cycle `brownout_rst` pulse. That edge restarts the sequence, from any state including error, and the next read request follows 22*CLK_KHZ cycles later.
- R9: `supply_ok` low at an edge at or after 27*CLK_KHZ cycles from the sequence start gives no `brownout_rst` and leaves the state unchanged.
- R10: While reset is applied, `rts` is high and `rd_req`, `tx_valid`, `boot_err`, `boot_done` and `brownout_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good level, low on a dip |
| rd_req | output | 1 | Storage read request |
| rd_addr | output | ADDR_W | Word address of the current read |
| rd_ack | input | 1 | Storage read acknowledge |
| rts | output | 1 | Flow-control line to host, high = not ready |
| tx_valid | output | 1 | Ready-message byte is offered |
| tx_byte | output | 8 | Ready-message byte |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| boot_err | output | 1 | Load timed out |
| boot_done | output | 1 | Ready message fully sent |
| brownout_rst | output | 1 | One-cycle pulse on a supply dip inside the window |

## Verification
The bench sweeps acknowledge latencies from zero up to the last legal cycle before timeout. An off-by-one timeout would either reject the late acknowledge or accept one cycle too many. It drops the supply at offsets just below and just at the window edge: a window compare with the wrong bound would restart on a harmless dip or miss a dangerous one. It also drops the supply during the load and from the error state, where a design that fails to clear its loader would keep requesting or stay in error. Transmitter back-pressure sweeps catch bytes that change or advance without a handshake, and exact cycle counts catch a start delay that is off by one.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_LOAD = 3'd1,
    ST_SEND = 3'd2,
    ST_DONE = 3'd3,
    ST_ERR  = 3'd4
  } boot_state_t;

  localparam int MSG_LEN = 3;

  // ready message characters, in transmit order
  function automatic logic [7:0] msg_char(input logic [1:0] idx);
    case (idx)
      2'd0:    msg_char = 8'h52;
      2'd1:    msg_char = 8'h4F;
      default: msg_char = 8'h4B;
    endcase
  endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
  parameter int DELAY_CYC = 88,
  parameter int GUARD_CYC = 108
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic delay_hit,
  output logic in_window
);
  localparam int TW = $clog2(GUARD_CYC + 1);
  localparam logic [TW-1:0] GUARD_T = TW'(GUARD_CYC);
  localparam logic [TW-1:0] HIT_T   = TW'(DELAY_CYC - 1);

  logic [TW-1:0] ticks_q, ticks_d;
  logic          ticks_en;

  always_comb begin
    ticks_en = 1'b0;
    ticks_d  = ticks_q;
    if (restart) begin
      ticks_en = 1'b1;
      ticks_d  = '0;
    end else if (ticks_q != GUARD_T) begin
      ticks_en = 1'b1;
      ticks_d  = ticks_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ticks_q <= '0;
    else if (ticks_en) ticks_q <= ticks_d;
  end

  assign delay_hit = (ticks_q == HIT_T);
  assign in_window = (ticks_q < GUARD_T);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int NUM_WORDS   = 16,
  parameter int TIMEOUT_CYC = 64,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic              rd_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic              fail
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NUM_WORDS - 1);
  localparam logic [TW-1:0]     LIM_W  = TW'(TIMEOUT_CYC - 1);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [TW-1:0]     wc_q, wc_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    wc_d   = wc_q;
    done_d = 1'b0;
    fail_d = 1'b0;
    if (clr) begin
      busy_d = 1'b0;
      idx_d  = '0;
      wc_d   = '0;
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
      wc_d   = '0;
    end else if (busy_q) begin
      if (rd_ack) begin
        wc_d = '0;
        if (idx_q == LAST_A) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else if (wc_q == LIM_W) begin
        busy_d = 1'b0;
        fail_d = 1'b1;
      end else begin
        wc_d = wc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      wc_q   <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      wc_q   <= wc_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign rd_req  = busy_q;
  assign rd_addr = idx_q;
  assign done    = done_q;
  assign fail    = fail_q;

endmodule

// File: rtl/ready_tx.sv
module ready_tx
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       start,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       fin
);
  localparam logic [1:0] LAST_B = 2'(MSG_LEN - 1);

  logic       act_q, act_d;
  logic [1:0] bi_q, bi_d;
  logic       fin_q, fin_d;

  always_comb begin
    act_d = act_q;
    bi_d  = bi_q;
    fin_d = 1'b0;
    if (clr) begin
      act_d = 1'b0;
      bi_d  = '0;
    end else if (start) begin
      act_d = 1'b1;
      bi_d  = '0;
    end else if (act_q && tx_ready) begin
      if (bi_q == LAST_B) begin
        act_d = 1'b0;
        fin_d = 1'b1;
      end else begin
        bi_d = bi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      bi_q  <= '0;
      fin_q <= 1'b0;
    end else begin
      act_q <= act_d;
      bi_q  <= bi_d;
      fin_q <= fin_d;
    end
  end

  assign tx_valid = act_q;
  assign tx_byte  = msg_char(bi_q);
  assign fin      = fin_q;

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_pkg::*;
#(
  parameter int CLK_KHZ     = 32000,
  parameter int NUM_WORDS   = 16,
  parameter int ACK_TIMEOUT = 64,
  parameter int ADDR_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  output logic              rts,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  output logic              boot_err,
  output logic              boot_done,
  output logic              brownout_rst
);
  localparam int DELAY_CYC = 22 * CLK_KHZ;
  localparam int GUARD_CYC = 27 * CLK_KHZ;
  localparam int SYNC_N    = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_N-1:0] rsync_q;
  logic              rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_i = rsync_q[SYNC_N-1];

  boot_state_t state_q, state_d;
  logic delay_hit, in_window, restart;
  logic ld_start, ld_done, ld_fail;
  logic tx_start, tx_fin;
  logic bo_q;

  assign restart = !supply_ok && in_window;

  boot_timer #(
    .DELAY_CYC (DELAY_CYC),
    .GUARD_CYC (GUARD_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_i),
    .restart   (restart),
    .delay_hit (delay_hit),
    .in_window (in_window)
  );

  assign ld_start = (state_q == ST_WAIT) && delay_hit && !restart;

  cfg_loader #(
    .NUM_WORDS   (NUM_WORDS),
    .TIMEOUT_CYC (ACK_TIMEOUT),
    .ADDR_W      (ADDR_W)
  ) u_loader (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (restart),
    .start   (ld_start),
    .rd_ack  (rd_ack),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .done    (ld_done),
    .fail    (ld_fail)
  );

  assign tx_start = (state_q == ST_LOAD) && ld_done && !restart;

  ready_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (restart),
    .start    (tx_start),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .fin      (tx_fin)
  );

  always_comb begin
    state_d = state_q;
    if (restart) begin
      state_d = ST_WAIT;
    end else begin
      case (state_q)
        ST_WAIT: if (delay_hit) state_d = ST_LOAD;
        ST_LOAD: begin
          if (ld_done)      state_d = ST_SEND;
          else if (ld_fail) state_d = ST_ERR;
        end
        ST_SEND: if (tx_fin) state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_WAIT;
      bo_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bo_q    <= restart;
    end
  end

  assign rts          = (state_q == ST_WAIT) || (state_q == ST_LOAD) || (state_q == ST_ERR);
  assign boot_err     = (state_q == ST_ERR);
  assign boot_done    = (state_q == ST_DONE);
  assign brownout_rst = bo_q;

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_ok,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic              rts,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              tx_ready,
  input logic              boot_err,
  input logic              boot_done,
  input logic              brownout_rst
);

  // R2
  a_r2_rts_during_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rts);

  // R3
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack && supply_ok |=> !rd_req || $stable(rd_addr));

  // R4
  a_r4_tx_only_rts_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rts && !rd_req);

  // R5
  a_r5_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && supply_ok |=> tx_valid && $stable(tx_byte));

  // R6
  a_r6_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done && supply_ok |=> boot_done && !tx_valid && !rts);

  // R7
  a_r7_err_parks: assert property (@(posedge clk) disable iff (!rst_n)
    boot_err && supply_ok |=> boot_err && rts && !rd_req);

  // R8
  a_r8_restart_clean: assert property (@(posedge clk) disable iff (!rst_n)
    brownout_rst |-> rts && !rd_req && !tx_valid && !boot_err && !boot_done);

  // R4, R2: never request and transmit together
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, tx_valid, boot_done, boot_err}));

endmodule

bind boot_seq_top boot_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_boot_seq_top.sv
`timescale 1ns/1ps
module tb_boot_seq_top;
  localparam int CLK_KHZ = 4;
  localparam int NW      = 4;
  localparam int TO      = 16;
  localparam int AW      = 2;
  localparam int DLY     = 22 * CLK_KHZ;
  localparam int GRD     = 27 * CLK_KHZ;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          supply_ok;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack;
  logic          rts;
  logic          tx_valid;
  logic [7:0]    tx_byte;
  logic          tx_ready;
  logic          boot_err;
  logic          boot_done;
  logic          brownout_rst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  boot_seq_top #(
    .CLK_KHZ     (CLK_KHZ),
    .NUM_WORDS   (NW),
    .ACK_TIMEOUT (TO),
    .ADDR_W      (AW)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .rd_req       (rd_req),
    .rd_addr      (rd_addr),
    .rd_ack       (rd_ack),
    .rts          (rts),
    .tx_valid     (tx_valid),
    .tx_byte      (tx_byte),
    .tx_ready     (tx_ready),
    .boot_err     (boot_err),
    .boot_done    (boot_done),
    .brownout_rst (brownout_rst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reset, then align to the sequence start (two edges after release)
  task automatic do_reset();
    rst_n     = 1'b0;
    supply_ok = 1'b1;
    rd_ack    = 1'b0;
    tx_ready  = 1'b0;
    repeat (3) @(negedge clk);
    chk(rts && !rd_req && !tx_valid && !boot_err && !boot_done && !brownout_rst,
        "R10 reset outputs", {rts, rd_req, tx_valid, boot_err, boot_done, brownout_rst}, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!rd_req && n < DLY + 60) begin
      @(negedge clk);
      n++;
      if (!rd_req) chk(rts, "R2 rts high before load", rts, 1);
    end
  endtask

  task automatic run_boot(input int lat, input int txlat);
    int n;
    logic [7:0] expb;
    do_reset();
    wait_req(n);
    chk(n == DLY, "R1 start delay", n, DLY);
    for (int w = 0; w < NW; w++) begin
      chk(rd_req && rd_addr == w, "R3 address order", rd_addr, w);
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        chk(rd_req && rd_addr == w && rts, "R3 request held", rd_addr, w);
      end
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
    end
    chk(rts && !tx_valid, "R2 rts high until load ends", rts, 1);
    @(negedge clk);
    chk(!rts && tx_valid && !rd_req, "R4 rts low then message", {rts, tx_valid, rd_req}, 3'b010);
    for (int b = 0; b < 3; b++) begin
      expb = (b == 0) ? 8'h52 : (b == 1) ? 8'h4F : 8'h4B;
      chk(tx_valid && tx_byte == expb, "R5 byte order", tx_byte, expb);
      for (int c = 0; c < txlat; c++) begin
        @(negedge clk);
        chk(tx_valid && tx_byte == expb, "R5 byte held", tx_byte, expb);
      end
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    chk(!tx_valid && !boot_done, "R6 valid drops", {tx_valid, boot_done}, 0);
    @(negedge clk);
    chk(boot_done && !rts, "R6 done flag", {boot_done, rts}, 2'b10);
    repeat (5) @(negedge clk);
    chk(boot_done && !rts && !tx_valid && !rd_req, "R6 done stays", boot_done, 1);
  endtask

  task automatic run_timeout();
    int n;
    do_reset();
    wait_req(n);
    n = 0;
    while (!boot_err && n < TO + 10) begin
      @(negedge clk);
      n++;
    end
    chk(n == TO + 1, "R7 timeout cycles", n, TO + 1);
    chk(rts && !rd_req && !tx_valid, "R7 error parks with rts high", {rts, rd_req, tx_valid}, 3'b100);
    repeat (10) @(negedge clk);
    chk(boot_err && rts && !rd_req, "R7 error sticks", boot_err, 1);
  endtask

  // supply dip sampled at edge k+1 (counter value k); no acknowledges given
  task automatic run_dip(input int k);
    int  n;
    bit  exp_rs;
    bit  exp_err;
    exp_rs  = (k < GRD);
    exp_err = (k + 1 >= DLY + TO + 1);
    do_reset();
    repeat (k) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    if (exp_rs) begin
      chk(brownout_rst == 1'b1, "R8 brownout pulse", brownout_rst, 1);
      chk(rts && !rd_req && !boot_err, "R8 back to wait", {rts, rd_req, boot_err}, 3'b100);
      @(negedge clk);
      chk(brownout_rst == 1'b0, "R8 single pulse", brownout_rst, 0);
      wait_req(n);
      chk(n == DLY - 1, "R8 restart delay", n + 1, DLY);
    end else begin
      chk(brownout_rst == 1'b0, "R9 dip ignored pulse", brownout_rst, 0);
      chk(boot_err == exp_err, "R9 dip ignored state", boot_err, exp_err);
      chk(rts == 1'b1, "R9 rts unchanged", rts, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lats[6] = '{0, 1, 2, 3, 5, TO - 1};
    int dips[8] = '{0, 40, DLY - 1, 95, GRD - 2, GRD - 1, GRD, 200};
    for (int i = 0; i < 6; i++) run_boot(lats[i], i % 4);
    run_timeout();
    for (int i = 0; i < 8; i++) run_dip(dips[i]);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule